// File: doc/BRIEF.md
# Serial Gamepad Button Poller

This block reads an eight-button game controller over a three-wire serial link. It runs without any request from software. It raises a latch strobe, then sends a train of clock pulses, and shifts in one button per step from the controller's data line. A divider makes a one-microsecond tick from the system clock, and the widths of all phases are counted in that tick.

Each finished capture is copied into an eight-bit holding register. A processor read at the mapped location returns that register combinationally in the same cycle, so software never waits on the serial cycle, which takes several hundred microseconds. Debouncing and suppression of repeated presses are left to software.

Top module: `gp_poller`

## Requirements
- R1: While reset is asserted, and from then until the first capture completes, pad_latch_o and pad_pulse_o are low and a read returns 0x00. Reset takes effect at once, even in the middle of a poll.
- R2: Each poll starts with pad_latch_o high for LATCH_US microseconds (12 by default), which is LATCH_US*CLK_HZ/1e6 system clock cycles.
- R3: After pad_latch_o falls, both strobes stay low for SETTLE_US microseconds (6) before the first pulse rises.
- R4: Each poll has exactly NBITS pulses (8), and each pulse is high for PULSE_HI_US microseconds (6).
- R5: Two consecutive pulses in a poll are separated by PULSE_LO_US microseconds (6) of low time.
- R6: After the last pulse falls, both strobes stay low for IDLE_US microseconds (100) before the next latch rises.
- R7: Polls repeat back to back with rd_en_i held low. The start of one latch to the start of the next is LATCH_US+SETTLE_US+NBITS*PULSE_HI_US+(NBITS-1)*PULSE_LO_US+IDLE_US microseconds.
- R8: The data line is active low and a stored 1 means pressed. The bit sampled at the end of the latch goes to rd_data_o[0]. The bit sampled at the end of the k-th pulse's high phase (k = 1..NBITS-1) goes to rd_data_o[k]. The level on the line during and after the last pulse is never stored.
- R9: The holding register changes only when a capture completes, at the end of pulse NBITS-1. Before that point in a poll, a read returns the previous poll's value.
- R10: With rd_en_i high, rd_data_o shows the holding register in the same cycle. With rd_en_i low, rd_data_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_data_i | input | 1 | Serial button data from the controller, low = pressed |
| pad_latch_o | output | 1 | Latch strobe to the controller |
| pad_pulse_o | output | 1 | Shift clock pulses to the controller |
| rd_en_i | input | 1 | Processor read select for the button register |
| rd_data_o | output | NBITS | Button state, 1 = pressed; zero when not selected |

## Verification
The hardest condition to reach from the ports is a read in the middle of a capture. The shift register then holds most of the new buttons, and the holding register must still show the old ones. The bench uses a behavioural controller that changes its answer on every poll. It reads back after the sixth pulse and also right at the next latch, and in both cases expects the previous pattern. The last pulse is driven so that a pressed level follows it, which would corrupt the top bit if the design ever stored an extra sample. A reset during the pulse train checks that the strobes stop at once and that a later clean poll captures correctly.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LATCH  = 3'd1,
    PH_SETTLE = 3'd2,
    PH_PHI    = 3'd3,
    PH_PLO    = 3'd4
  } gp_phase_e;

  function automatic int gp_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/gp_rst_sync.sv
module gp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/gp_us_tick.sv
module gp_us_tick #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  generate
    if (DIV > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/gp_sequencer.sv
module gp_sequencer
  import gp_pkg::*;
#(
  parameter int NBITS       = 8,
  parameter int LATCH_US    = 12,
  parameter int SETTLE_US   = 6,
  parameter int PULSE_HI_US = 6,
  parameter int PULSE_LO_US = 6,
  parameter int IDLE_US     = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic latch_o,
  output logic pulse_o,
  output logic sample_o,
  output logic last_o
);
  localparam int MAXD = gp_max(gp_max(gp_max(LATCH_US, SETTLE_US),
                                      gp_max(PULSE_HI_US, PULSE_LO_US)), IDLE_US);
  localparam int UW = $clog2(MAXD + 1);
  localparam int PW = $clog2(NBITS);

  gp_phase_e     state_q, state_d;
  logic [UW-1:0] us_q, us_d;
  logic [PW-1:0] pidx_q, pidx_d;
  logic [UW-1:0] span_m1;
  logic          phase_end;
  logic          at_last_pulse;

  always_comb begin
    case (state_q)
      PH_LATCH:  span_m1 = UW'(LATCH_US - 1);
      PH_SETTLE: span_m1 = UW'(SETTLE_US - 1);
      PH_PHI:    span_m1 = UW'(PULSE_HI_US - 1);
      PH_PLO:    span_m1 = UW'(PULSE_LO_US - 1);
      default:   span_m1 = UW'(IDLE_US - 1);
    endcase
  end

  assign phase_end     = tick_i && (us_q == span_m1);
  assign at_last_pulse = (pidx_q == PW'(NBITS - 1));

  always_comb begin
    state_d = state_q;
    us_d    = us_q;
    pidx_d  = pidx_q;
    if (tick_i) begin
      if (phase_end) us_d = '0;
      else           us_d = us_q + 1'b1;
    end
    if (phase_end) begin
      case (state_q)
        PH_IDLE:   state_d = PH_LATCH;
        PH_LATCH:  state_d = PH_SETTLE;
        PH_SETTLE: begin
          state_d = PH_PHI;
          pidx_d  = '0;
        end
        PH_PHI:    state_d = at_last_pulse ? PH_IDLE : PH_PLO;
        PH_PLO:    begin
          state_d = PH_PHI;
          pidx_d  = pidx_q + 1'b1;
        end
        default:   state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      us_q    <= '0;
      pidx_q  <= '0;
    end else begin
      state_q <= state_d;
      us_q    <= us_d;
      pidx_q  <= pidx_d;
    end
  end

  assign latch_o  = (state_q == PH_LATCH);
  assign pulse_o  = (state_q == PH_PHI);
  assign sample_o = phase_end &&
                    ((state_q == PH_LATCH) || ((state_q == PH_PHI) && !at_last_pulse));
  assign last_o   = phase_end && (state_q == PH_PHI) && (pidx_q == PW'(NBITS - 2));

  // checker state: pulse rises counted per poll
  logic          chk_pulse_prev_q;
  logic [PW:0]   chk_pcnt_q;
  logic          chk_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_pulse_prev_q <= 1'b0;
      chk_pcnt_q       <= '0;
      chk_seen_q       <= 1'b0;
    end else begin
      chk_pulse_prev_q <= pulse_o;
      if (latch_o) chk_pcnt_q <= '0;
      else if (pulse_o && !chk_pulse_prev_q) chk_pcnt_q <= chk_pcnt_q + 1'b1;
      if (pulse_o) chk_seen_q <= 1'b1;
    end
  end

  // R4
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && !$past(latch_o) && chk_seen_q) |-> (chk_pcnt_q == (PW+1)'(NBITS)));

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_o) |=> !pulse_o);
endmodule

// File: rtl/gp_capture.sv
module gp_capture #(
  parameter int NBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_i,
  input  logic             sample_i,
  input  logic             last_i,
  output logic [NBITS-1:0] hold_o
);
  localparam int CNW = $clog2(NBITS) + 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [NBITS-1:0]       sr_q, sr_d;
  logic [NBITS-1:0]       hold_q, hold_d;
  logic                   line_s;

  assign line_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pad_i};
    sr_d   = sr_q;
    hold_d = hold_q;
    if (sample_i) sr_d = {~line_s, sr_q[NBITS-1:1]};
    if (last_i)   hold_d = sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      sr_q   <= '0;
      hold_q <= '0;
    end else begin
      sync_q <= sync_d;
      sr_q   <= sr_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

  // checker state: samples since the last publish
  logic [CNW-1:0] chk_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_n_q <= '0;
    else if (last_i) chk_n_q <= '0;
    else if (sample_i) chk_n_q <= chk_n_q + 1'b1;
  end

  // R8
  sample_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |-> (sample_i && (chk_n_q == CNW'(NBITS - 1))));
endmodule

// File: rtl/gp_poller.sv
module gp_poller #(
  parameter int CLK_HZ      = 10_000_000,
  parameter int NBITS       = 8,
  parameter int LATCH_US    = 12,
  parameter int SETTLE_US   = 6,
  parameter int PULSE_HI_US = 6,
  parameter int PULSE_LO_US = 6,
  parameter int IDLE_US     = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_data_i,
  output logic             pad_latch_o,
  output logic             pad_pulse_o,
  input  logic             rd_en_i,
  output logic [NBITS-1:0] rd_data_o
);
  localparam int DIV    = CLK_HZ / 1_000_000;
  localparam int LW_CYC = LATCH_US * DIV;
  localparam int LW     = $clog2(LW_CYC + 2);

  logic             rst_n_s;
  logic             tick;
  logic             sample;
  logic             last;
  logic [NBITS-1:0] hold_w;

  gp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  gp_us_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick_o (tick)
  );

  gp_sequencer #(
    .NBITS       (NBITS),
    .LATCH_US    (LATCH_US),
    .SETTLE_US   (SETTLE_US),
    .PULSE_HI_US (PULSE_HI_US),
    .PULSE_LO_US (PULSE_LO_US),
    .IDLE_US     (IDLE_US)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick_i   (tick),
    .latch_o  (pad_latch_o),
    .pulse_o  (pad_pulse_o),
    .sample_o (sample),
    .last_o   (last)
  );

  gp_capture #(.NBITS(NBITS), .SYNC_STAGES(2)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pad_i    (pad_data_i),
    .sample_i (sample),
    .last_i   (last),
    .hold_o   (hold_w)
  );

  assign rd_data_o = rd_en_i ? hold_w : '0;

  // checker state: latch high width in system cycles
  logic          chk_latch_prev_q;
  logic [LW-1:0] chk_lw_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      chk_latch_prev_q <= 1'b0;
      chk_lw_q         <= '0;
    end else begin
      chk_latch_prev_q <= pad_latch_o;
      if (pad_latch_o) chk_lw_q <= chk_lw_q + 1'b1;
      else             chk_lw_q <= '0;
    end
  end

  // R2
  latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (chk_latch_prev_q && !pad_latch_o) |-> (chk_lw_q == LW'(LW_CYC)));

  // R9
  hold_update_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(hold_w) |-> $past(pad_pulse_o));
endmodule

// File: tb/gp_poller_tb_top.sv
module gp_poller_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int DIV        = CLK_HZ / 1_000_000;
  localparam int NB         = 8;

  localparam int T_LATCH  = 12 * DIV;
  localparam int T_SETTLE = 6 * DIV;
  localparam int T_HI     = 6 * DIV;
  localparam int T_LO     = 6 * DIV;
  localparam int T_IDLE   = 100 * DIV;
  localparam int T_POLL   = T_LATCH + T_SETTLE + NB * T_HI + (NB - 1) * T_LO + T_IDLE;

  // {buttons held by the controller, expected register value}
  localparam logic [15:0] VEC [0:5] = '{
    {8'hA5, 8'hA5}, {8'hFF, 8'hFF}, {8'h01, 8'h01},
    {8'h80, 8'h80}, {8'h3C, 8'h3C}, {8'h00, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pad_data;
  logic          pad_latch;
  logic          pad_pulse;
  logic          rd_en;
  logic [NB-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gp_poller #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pad_data_i  (pad_data),
    .pad_latch_o (pad_latch),
    .pad_pulse_o (pad_pulse),
    .rd_en_i     (rd_en),
    .rd_data_o   (rd_data)
  );

  // behavioural controller: loads on latch, advances on pulse rise, low = pressed
  logic [7:0] btn   = 8'h00;
  logic [7:0] btn_l = 8'h00;
  int         idx   = 8;
  always @(posedge pad_latch or posedge pad_pulse) begin
    if (pad_latch) begin
      btn_l = btn;
      idx   = 0;
    end else begin
      idx = idx + 1;
    end
  end
  assign pad_data = (idx < 8) ? ~btn_l[idx[2:0]] : 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_latch_rise();
    @(negedge clk);
    while (pad_latch === 1'b1) @(negedge clk);
    while (pad_latch !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_pulse_falls(input int n);
    for (int i = 0; i < n; i++) begin
      while (pad_pulse !== 1'b1) @(negedge clk);
      while (pad_pulse === 1'b1) @(negedge clk);
    end
  endtask

  task automatic read_reg(output logic [NB-1:0] v);
    rd_en = 1'b1;
    #1;
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic measure_poll();
    int n;
    int total;
    int npulse;
    bit stray;
    wait_latch_rise();
    n = 0;
    while (pad_latch === 1'b1) begin n++; @(negedge clk); end
    chk("R2 latch width", n, T_LATCH);
    total = n;
    n = 0;
    while (pad_pulse !== 1'b1 && pad_latch !== 1'b1) begin n++; @(negedge clk); end
    chk("R3 settle gap", n, T_SETTLE);
    total += n;
    npulse = 0;
    for (int p = 0; p < NB; p++) begin
      n = 0;
      while (pad_pulse === 1'b1) begin n++; @(negedge clk); end
      npulse++;
      if (p == 0 || p == NB - 1) chk("R4 pulse high width", n, T_HI);
      total += n;
      if (p < NB - 1) begin
        n = 0;
        while (pad_pulse !== 1'b1) begin n++; @(negedge clk); end
        if (p == 0 || p == NB - 2) chk("R5 pulse low width", n, T_LO);
        total += n;
      end
    end
    n = 0;
    stray = 1'b0;
    while (pad_latch !== 1'b1) begin
      if (pad_pulse === 1'b1) stray = 1'b1;
      n++;
      @(negedge clk);
    end
    chk("R4 pulse count", npulse + int'(stray), NB);
    chk("R6 idle gap", n, T_IDLE);
    total += n;
    chk("R7 poll period with no reads", total, T_POLL);
  endtask

  initial begin
    logic [NB-1:0] v;
    logic [NB-1:0] prev;
    rst_n = 1'b0;
    rd_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 latch in reset", pad_latch, 1'b0);
    chk("R1 pulse in reset", pad_pulse, 1'b0);
    read_reg(v);
    chk("R1 register in reset", v, 8'h00);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 latch before first poll", pad_latch, 1'b0);
    read_reg(v);
    chk("R1 register before first capture", v, 8'h00);

    measure_poll();
    prev = 8'h00;

    for (int k = 0; k < 6; k++) begin
      btn = VEC[k][15:8];
      wait_latch_rise();
      read_reg(v);
      chk("R9 old value at latch", v, prev);
      wait_pulse_falls(6);
      read_reg(v);
      chk("R9 old value mid capture", v, prev);
      wait_pulse_falls(2);
      read_reg(v);
      chk("R8 captured buttons", v, VEC[k][7:0]);
      if (k == 0) begin
        rd_en = 1'b0;
        #1;
        chk("R10 unselected read is zero", rd_data, 8'h00);
        rd_en = 1'b1;
        #1;
        chk("R10 same-cycle read", rd_data, VEC[k][7:0]);
        rd_en = 1'b0;
      end
      prev = VEC[k][7:0];
    end

    // reset in the middle of the pulse train
    btn = 8'h5A;
    wait_latch_rise();
    wait_pulse_falls(3);
    while (pad_pulse !== 1'b1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 pulse stops on reset", pad_pulse, 1'b0);
    chk("R1 latch low on reset", pad_latch, 1'b0);
    rd_en = 1'b1;
    #1;
    chk("R1 register cleared on reset", rd_data, 8'h00);
    rd_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_latch_rise();
    wait_pulse_falls(8);
    read_reg(v);
    chk("R8 capture after reset", v, 8'h5A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule